// File: doc/BRIEF.md
# Pixel Line Packer with Alignment Padding

This block takes a stream of pixel components, one per handshake, and packs them into 128-bit output words for a host-side bus. A line uses a single component size throughout: either 8-bit components, which fill consecutive bytes, or 16-bit components, which fill consecutive byte pairs with the low byte first. An end-of-line marker comes with the final component of each line.

When a line ends, the current word is closed. The unused bytes are filled with zero padding up to the chosen alignment, which is 64 or 128 bits, and the word carries a last flag. The next line always starts at byte 0 of a fresh word. Component size and alignment are read from configuration inputs when a line's first component is accepted, and they then stay fixed until that line ends.

Both sides use a valid/ready handshake. A single output holding register means that back-pressure on the output stalls the input directly.

Top module: `line_packer`

## Requirements
- R1: With 8-bit components, component k of a line (counting from 0) appears in output word k/16 at bits [8*(k%16)+7 : 8*(k%16)], with no gaps.
- R2: With 16-bit components, component j occupies byte pair j%8 of word j/8: its bits [7:0] go in byte 2*(j%8) and bits [15:8] in byte 2*(j%8)+1.
- R3: With 8-bit components, in_data[15:8] has no effect on the output.
- R4: Padding bytes are zero and their out_keep bits are 1. With 128-bit alignment (cfg_align_full=1), the last word of every line has out_keep = 16'hFFFF.
- R5: With 64-bit alignment (cfg_align_full=0), the last word has out_keep = 16'h00FF if the line's final data byte is in bytes 0..7, and 16'hFFFF otherwise. Bytes not kept are zero.
- R6: A line that ends exactly on a word boundary gives no extra word. A line that ends exactly at byte 8 with 64-bit alignment gives out_keep = 16'h00FF and no padding bytes.
- R7: out_last is 1 only on a line's final word. Every word that is not last has out_keep = 16'hFFFF. The following line begins at byte 0 of a new word.
- R8: cfg_wide (1 = 16-bit) and cfg_align_full are sampled with the first component of a line. Changes to them later in the line have no effect.
- R9: While out_valid=1 and out_ready=0, out_data, out_keep and out_last stay stable and in_ready=0. No component is lost or duplicated.
- R10: After reset, out_valid=0 and in_ready=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wide | input | 1 | 1: 16-bit components, 0: 8-bit components |
| cfg_align_full | input | 1 | 1: 128-bit line alignment, 0: 64-bit |
| in_valid | input | 1 | Component valid |
| in_ready | output | 1 | Component accepted when high with in_valid |
| in_data | input | 16 | Component value (low byte only in 8-bit mode) |
| in_eol | input | 1 | Marks the last component of a line |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 128 | Packed bytes, byte 0 in bits [7:0] |
| out_keep | output | 16 | Per-byte enable |
| out_last | output | 1 | Final word of a line |

## Verification
The assertions assume that the input side obeys the handshake: in_data and in_eol are taken as meaningful only in the cycle in which in_valid and in_ready are both high. They also assume that a line never changes component size in the middle of a word except through the configuration inputs, which the block ignores once the line is open. The stimulus drives inputs only on the falling edge and holds each component until it is accepted. It changes the configuration only at line starts, except in the deliberate mid-line change test. Output back-pressure comes from a free-running pseudo-random pattern, so stalls hit both mid-line and end-of-line words.

// File: rtl/lp_pkg.sv
package lp_pkg;
    typedef enum logic {
        COMP_BYTE = 1'b0,
        COMP_PAIR = 1'b1
    } comp_size_e;

    typedef enum logic {
        ALIGN_HALF = 1'b0,
        ALIGN_FULL = 1'b1
    } align_e;
endpackage

// File: rtl/lp_byte_place.sv
module lp_byte_place #(
    parameter int OUT_BYTES = 16,
    localparam int PTR_W = $clog2(OUT_BYTES),
    localparam int DATA_W = OUT_BYTES * 8
) (
    input  logic [DATA_W-1:0] acc_i,
    input  logic [PTR_W-1:0]  ptr_i,
    input  logic              pair_i,
    input  logic [15:0]       comp_i,
    output logic [DATA_W-1:0] acc_o
);
    for (genvar b = 0; b < OUT_BYTES; b++) begin : g_byte
        localparam int PREV = (b == 0) ? 0 : b - 1;
        localparam bit HAS_PREV = (b != 0);
        logic lo_hit;
        logic hi_hit;
        always_comb begin
            lo_hit = (ptr_i == PTR_W'(b));
            hi_hit = HAS_PREV && pair_i && (ptr_i == PTR_W'(PREV));
            if (lo_hit) begin
                acc_o[b*8 +: 8] = comp_i[7:0];
            end else if (hi_hit) begin
                acc_o[b*8 +: 8] = comp_i[15:8];
            end else begin
                acc_o[b*8 +: 8] = acc_i[b*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/lp_tail_mask.sv
module lp_tail_mask #(
    parameter int OUT_BYTES = 16,
    localparam int PTR_W = $clog2(OUT_BYTES),
    localparam int HALF = OUT_BYTES / 2
) (
    input  logic [PTR_W:0]     fill_i,
    input  logic               full_align_i,
    output logic [OUT_BYTES-1:0] keep_o
);
    always_comb begin
        if (full_align_i || (fill_i > (PTR_W+1)'(HALF))) begin
            keep_o = '1;
        end else begin
            keep_o = {{HALF{1'b0}}, {HALF{1'b1}}};
        end
    end
endmodule

// File: rtl/lp_out_stage.sv
module lp_out_stage #(
    parameter int OUT_BYTES = 16,
    localparam int DATA_W = OUT_BYTES * 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic [DATA_W-1:0]    data_i,
    input  logic [OUT_BYTES-1:0] keep_i,
    input  logic                 last_i,
    output logic                 free_o,
    output logic                 valid_o,
    input  logic                 ready_i,
    output logic [DATA_W-1:0]    data_o,
    output logic [OUT_BYTES-1:0] keep_o,
    output logic                 last_o
);
    typedef struct packed {
        logic                 valid;
        logic [DATA_W-1:0]    data;
        logic [OUT_BYTES-1:0] keep;
        logic                 last;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.valid && ready_i) begin
            st_d.valid = 1'b0;
        end
        if (load_i) begin
            st_d.valid = 1'b1;
            st_d.data  = data_i;
            st_d.keep  = keep_i;
            st_d.last  = last_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign free_o  = !st_q.valid || ready_i;
    assign valid_o = st_q.valid;
    assign data_o  = st_q.data;
    assign keep_o  = st_q.keep;
    assign last_o  = st_q.last;

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(data_o) && $stable(keep_o) && $stable(last_o)))
        else $error("stalled word changed");
endmodule

// File: rtl/line_packer.sv
module line_packer #(
    parameter int OUT_BYTES = 16,
    localparam int PTR_W = $clog2(OUT_BYTES),
    localparam int DATA_W = OUT_BYTES * 8,
    localparam int HALF = OUT_BYTES / 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wide,
    input  logic                 cfg_align_full,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [15:0]          in_data,
    input  logic                 in_eol,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [DATA_W-1:0]    out_data,
    output logic [OUT_BYTES-1:0] out_keep,
    output logic                 out_last
);
    import lp_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] acc;
        logic [PTR_W-1:0]  ptr;
        logic              in_line;
        comp_size_e        size;
        align_e            align;
    } pack_t;

    pack_t pk_d, pk_q;

    logic                 stage_free;
    logic                 fire;
    comp_size_e           eff_size;
    align_e               eff_align;
    logic [PTR_W:0]       fill;
    logic [DATA_W-1:0]    placed;
    logic [OUT_BYTES-1:0] tail_keep;
    logic                 flush;
    logic [OUT_BYTES-1:0] word_keep;

    lp_byte_place #(.OUT_BYTES(OUT_BYTES)) i_place (
        .acc_i (pk_q.acc),
        .ptr_i (pk_q.ptr),
        .pair_i(eff_size == COMP_PAIR),
        .comp_i(in_data),
        .acc_o (placed)
    );

    lp_tail_mask #(.OUT_BYTES(OUT_BYTES)) i_mask (
        .fill_i      (fill),
        .full_align_i(eff_align == ALIGN_FULL),
        .keep_o      (tail_keep)
    );

    always_comb begin
        in_ready  = stage_free;
        fire      = in_valid && stage_free;
        eff_size  = pk_q.in_line ? pk_q.size  : comp_size_e'(cfg_wide);
        eff_align = pk_q.in_line ? pk_q.align : align_e'(cfg_align_full);
        fill      = {1'b0, pk_q.ptr} + ((eff_size == COMP_PAIR) ? (PTR_W+1)'(2) : (PTR_W+1)'(1));
        flush     = fire && (in_eol || (fill == (PTR_W+1)'(OUT_BYTES)));
        word_keep = in_eol ? tail_keep : '1;

        pk_d = pk_q;
        if (fire) begin
            pk_d.size    = eff_size;
            pk_d.align   = eff_align;
            pk_d.in_line = !in_eol;
            if (flush) begin
                pk_d.acc = '0;
                pk_d.ptr = '0;
            end else begin
                pk_d.acc = placed;
                pk_d.ptr = fill[PTR_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pk_q <= '0;
        end else begin
            pk_q <= pk_d;
        end
    end

    lp_out_stage #(.OUT_BYTES(OUT_BYTES)) i_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (flush),
        .data_i (placed),
        .keep_i (word_keep),
        .last_i (in_eol),
        .free_o (stage_free),
        .valid_o(out_valid),
        .ready_i(out_ready),
        .data_o (out_data),
        .keep_o (out_keep),
        .last_o (out_last)
    );

    // R9
    stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready)
        else $error("input accepted while output stalled");

    // R2
    pair_ptr_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_q.in_line && pk_q.size == COMP_PAIR) |-> !pk_q.ptr[0])
        else $error("odd byte pointer in 16-bit line");

    // R8
    mode_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_q.in_line && !(fire && in_eol)) |=> ($stable(pk_q.size) && $stable(pk_q.align)))
        else $error("line mode changed mid-line");

    // R7
    mid_word_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |-> (&out_keep))
        else $error("non-last word with partial keep");

    // R5
    keep_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((&out_keep) || (out_keep == {{HALF{1'b0}}, {HALF{1'b1}}})))
        else $error("keep not on an alignment boundary");
endmodule

// File: tb/test_line_packer.sv
module test_line_packer;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_wide = 1'b0;
    logic         cfg_align_full = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [15:0]  in_data = '0;
    logic         in_eol = 1'b0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [127:0] out_data;
    logic [15:0]  out_keep;
    logic         out_last;

    always #4 clk = ~clk;

    line_packer i_line_packer (
        .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_align_full(cfg_align_full),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_eol(in_eol),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_keep(out_keep), .out_last(out_last)
    );

    typedef struct {
        logic [127:0] d;
        logic [15:0]  k;
        logic         l;
        string        tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    int   seed = 7;
    bit   stall_mode = 1'b0;
    logic [7:0] lfsr = 8'h5A;
    bit   done = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [127:0] act, input logic [127:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // out_ready pattern
    always @(negedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready <= stall_mode ? (lfsr[0] | lfsr[2]) : 1'b1;
    end

    // monitor: pops expected words, checks stall hold
    bit           prev_stall = 1'b0;
    logic [127:0] prev_d;
    logic [15:0]  prev_k;
    logic         prev_l;
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (prev_stall) begin
                check(out_valid && out_data == prev_d && out_keep == prev_k && out_last == prev_l,
                      "R9", "stalled word changed", out_data, prev_d);
            end
            prev_stall = out_valid && !out_ready;
            prev_d = out_data;
            prev_k = out_keep;
            prev_l = out_last;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected word", out_data, '0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(out_data == e.d, e.tag, "data", out_data, e.d);
                    check(out_keep == e.k, e.tag, "keep", {112'b0, out_keep}, {112'b0, e.k});
                    check(out_last == e.l, "R7", "last", {127'b0, out_last}, {127'b0, e.l});
                end
            end
        end
    end

    // builds expected words, then drives the line
    task automatic send_line(input int n, input bit wide, input bit full, input bit flip,
                             input string tag);
        logic [7:0]  bytes[$];
        logic [15:0] comps[$];
        for (int i = 0; i < n; i++) begin
            logic [15:0] c;
            seed = seed * 1103 + 12345;
            c = seed[23:8];
            if (c[7:0] == 8'h00) c[7:0] = 8'h3C;
            if (!wide) c[15:8] = 8'hA5 ^ c[7:0];
            comps.push_back(c);
            bytes.push_back(c[7:0]);
            if (wide) bytes.push_back(c[15:8]);
        end
        for (int w = 0; w * 16 < bytes.size(); w++) begin
            exp_t e;
            int   cnt;
            e.d = '0;
            cnt = 0;
            for (int b = 0; b < 16; b++) begin
                if (w * 16 + b < bytes.size()) begin
                    e.d[b*8 +: 8] = bytes[w*16 + b];
                    cnt++;
                end
            end
            e.l = ((w + 1) * 16 >= bytes.size());
            if (!e.l || full || cnt > 8) e.k = 16'hFFFF;
            else e.k = 16'h00FF;
            e.tag = tag;
            exp_q.push_back(e);
        end
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = comps[i];
            in_eol   = (i == n - 1);
            if (i == 0) begin
                cfg_wide = wide;
                cfg_align_full = full;
            end else if (flip) begin
                cfg_wide = !wide;
                cfg_align_full = !full;
            end
            #2;
            while (!in_ready) begin
                @(negedge clk);
                #2;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_eol = 1'b0;
    endtask

    task automatic drain;
        int t;
        t = 0;
        while ((exp_q.size() != 0 || out_valid) && t < 2000) begin
            @(negedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        // R10
        check(out_valid == 1'b0, "R10", "out_valid in reset", {127'b0, out_valid}, '0);
        check(in_ready == 1'b1, "R10", "in_ready in reset", {127'b0, in_ready}, 128'd1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        check(out_valid == 1'b0, "R10", "out_valid after reset", {127'b0, out_valid}, '0);

        send_line(20, 1'b0, 1'b1, 1'b0, "R1");   // R1 R3 R4: 8-bit, two words, 128 pad
        drain();
        send_line(5, 1'b0, 1'b0, 1'b0, "R5");    // R5: short, low half kept
        drain();
        send_line(12, 1'b0, 1'b0, 1'b0, "R5");   // R5: crosses half, full keep
        drain();
        send_line(11, 1'b1, 1'b1, 1'b0, "R2");   // R2 R4: 16-bit little-endian
        drain();
        send_line(4, 1'b1, 1'b0, 1'b0, "R6");    // R6: exactly 8 bytes, half align
        drain();
        send_line(32, 1'b0, 1'b1, 1'b0, "R6");   // R6: exactly two words
        drain();
        send_line(8, 1'b1, 1'b1, 1'b1, "R8");    // R8: cfg flips mid-line
        drain();
        send_line(9, 1'b0, 1'b0, 1'b1, "R8");    // R8: flip to 16-bit ignored
        drain();
        send_line(1, 1'b0, 1'b0, 1'b0, "R7");    // R7: one-component line
        send_line(3, 1'b1, 1'b1, 1'b0, "R7");    // R7: next line at byte 0
        drain();

        stall_mode = 1'b1;                        // R9: back-pressure
        for (int ln = 0; ln < 24; ln++) begin
            send_line(1 + (ln * 7) % 37, ln[0], ln[1], ln[2], "R9");
        end
        drain();
        stall_mode = 1'b0;
        drain();

        // R9: nothing lost or duplicated
        check(exp_q.size() == 0, "R9", "words outstanding", 128'(exp_q.size()), '0);
        check(out_valid == 1'b0, "R9", "idle at end", {127'b0, out_valid}, '0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule